// File: doc/BRIEF.md
# I/O-Port Controlled Memory Region Mapper

This block keeps the memory map of a small 8-bit processor system and selects which target answers each memory access. The address space is cut into three windows: a low 4 KB window (0x0000 to 0x0FFF), a middle window (0x1000 to 0xCFFF) and a top 12 KB window (0xD000 to 0xFFFF). The low window shows either the monitor ROM or DRAM. The middle window is always DRAM. The top window shows DRAM or memory-mapped I/O, or nothing at all while inhibit mode is active.

Software changes the map only through I/O accesses to a group of eight consecutive ports, 0xE0 to 0xE7. The bus uses active-low strobes. A port access counts only when IORQ is low together with RD or WR. The state changes once per bus cycle, on the first rising clock edge at which the qualified strobe is seen. Holding the strobe longer has no further effect. The last port of the group carries a one-bit interrupt-enable flag. A write to it sets the flag and a read clears it. The region select output is combinational from the memory address, the memory request and the stored state.

There are no data streams here. All pins are plain control and status signals, with no valid/ready handshake and no back-pressure.

Top module: `bank_mapper_top`

## Requirements
- R1: When mem_req_n is low, an address in 0x1000..0xCFFF always selects DRAM. The low window is 0x0000..0x0FFF and the top window is 0xD000..0xFFFF.
- R2: An I/O write to port 0xE0 maps the low window to DRAM. An I/O write to 0xE2 maps it back to monitor ROM. The top window mapping is left unchanged.
- R3: An I/O write to port 0xE1 maps the top window to DRAM. An I/O write to 0xE3 maps it to memory-mapped I/O. The low window mapping is left unchanged.
- R4: An I/O write to port 0xE4 sets the low window to ROM and the top window to memory-mapped I/O in one step.
- R5: An I/O write to port 0xE5 enters inhibit. While inhibit is active, a top-window access selects the "none" code and the low window is unaffected.
- R6: An I/O write to port 0xE6 leaves inhibit. The top window then shows its stored mapping, including any change written with 0xE1, 0xE3 or 0xE4 while inhibit was active.
- R7: An I/O write to port 0xE7 sets irq_en. An I/O read of port 0xE7 clears it.
- R8: Reset (rst_n low, asynchronous) sets the low window to ROM and the top window to memory-mapped I/O, clears inhibit, and clears irq_en.
- R9: A port takes effect only when iorq_n is low together with wr_n (or rd_n, for 0xE7), and only when all eight address bits match. For example, a write with iorq_n high, or a write to 0x60, changes nothing.
- R10: The update happens on the first rising edge at which the qualified strobe is seen. If the strobe stays low while io_addr changes, no second update occurs.
- R11: region_sel is one-hot when mem_req_n is low and all zero when it is high. The bits are: bit 0 DRAM, bit 1 monitor ROM, bit 2 memory-mapped I/O, bit 3 none (inhibited).
- R12: Reads of ports 0xE0..0xE6 have no effect, and writes to ports outside 0xE0..0xE7 (for example 0xE8 or 0xD8) have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O port address |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| mem_req_n | input | 1 | Memory request, active low |
| mem_addr | input | 16 | Memory address |
| region_sel | output | 4 | One-hot region select: DRAM, ROM, MMIO, none |
| irq_en | output | 1 | Interrupt-enable flag |

## Verification
The assertions check these properties on every cycle:
- the one-hot or all-zero shape of region_sel;
- DRAM is always selected in the middle window;
- the low window never yields MMIO or "none", and the top window never yields ROM;
- irq_en reacts correctly to the first edge of a write or read of 0xE7 and stays stable while a strobe is merely held.

The bench scenarios are needed for the rest:
- the restore-after-inhibit behaviour, including updates made while inhibited;
- rejection of partly matching addresses and unqualified strobes;
- the address change under a held strobe;
- the reset values, checked both at start-up and after a mid-run reset.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

  localparam int REGION_W = 4;
  localparam int RGN_DRAM = 0;
  localparam int RGN_ROM  = 1;
  localparam int RGN_MMIO = 2;
  localparam int RGN_NONE = 3;

  typedef enum logic [3:0] {
    CMD_IDLE     = 4'd0,
    CMD_LOW_DRAM = 4'd1,
    CMD_TOP_DRAM = 4'd2,
    CMD_LOW_ROM  = 4'd3,
    CMD_TOP_MMIO = 4'd4,
    CMD_DEFAULT  = 4'd5,
    CMD_INH_ON   = 4'd6,
    CMD_INH_OFF  = 4'd7,
    CMD_IRQ_ON   = 4'd8,
    CMD_IRQ_OFF  = 4'd9
  } map_cmd_t;

  typedef struct packed {
    logic low_rom;
    logic top_mmio;
    logic inhibit;
    logic irq_en;
  } map_state_t;

endpackage

// File: rtl/bmap_port_decode.sv
module bmap_port_decode
  import bank_map_pkg::*;
#(
  parameter int IO_AW = 8,
  parameter logic [IO_AW-1:0] PORT_BASE = 8'hE0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             iorq_n,
  input  logic             rd_n,
  input  logic             wr_n,
  output map_cmd_t         cmd
);

  localparam int NPORTS = 8;
  localparam int OFF_W  = $clog2(NPORTS);

  logic             wr_q, rd_q;
  logic             wr_seen, rd_seen;
  logic             wr_first, rd_first;
  logic [IO_AW-1:0] off_full;
  logic             hit;
  logic [OFF_W-1:0] off;

  assign wr_q     = !iorq_n && !wr_n;
  assign rd_q     = !iorq_n && !rd_n;
  assign wr_first = wr_q && !wr_seen;
  assign rd_first = rd_q && !rd_seen;

  // Remember that the current bus cycle has already been acted on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_seen <= 1'b0;
      rd_seen <= 1'b0;
    end else begin
      wr_seen <= wr_q;
      rd_seen <= rd_q;
    end
  end

  assign off_full = io_addr - PORT_BASE;
  assign hit      = (off_full < IO_AW'(NPORTS));
  assign off      = off_full[OFF_W-1:0];

  always_comb begin
    cmd = CMD_IDLE;
    if (hit && wr_first) begin
      unique case (off)
        3'd0: cmd = CMD_LOW_DRAM;
        3'd1: cmd = CMD_TOP_DRAM;
        3'd2: cmd = CMD_LOW_ROM;
        3'd3: cmd = CMD_TOP_MMIO;
        3'd4: cmd = CMD_DEFAULT;
        3'd5: cmd = CMD_INH_ON;
        3'd6: cmd = CMD_INH_OFF;
        default: cmd = CMD_IRQ_ON;
      endcase
    end else if (hit && rd_first && off == OFF_W'(NPORTS - 1)) begin
      cmd = CMD_IRQ_OFF;
    end
  end

endmodule

// File: rtl/bmap_state.sv
module bmap_state
  import bank_map_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  map_cmd_t   cmd,
  output map_state_t st
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st.low_rom  <= 1'b1;
      st.top_mmio <= 1'b1;
      st.inhibit  <= 1'b0;
      st.irq_en   <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_LOW_DRAM: st.low_rom  <= 1'b0;
        CMD_LOW_ROM:  st.low_rom  <= 1'b1;
        CMD_TOP_DRAM: st.top_mmio <= 1'b0;
        CMD_TOP_MMIO: st.top_mmio <= 1'b1;
        CMD_DEFAULT: begin
          st.low_rom  <= 1'b1;
          st.top_mmio <= 1'b1;
        end
        CMD_INH_ON:  st.inhibit <= 1'b1;
        CMD_INH_OFF: st.inhibit <= 1'b0;
        CMD_IRQ_ON:  st.irq_en  <= 1'b1;
        CMD_IRQ_OFF: st.irq_en  <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bmap_region.sv
module bmap_region
  import bank_map_pkg::*;
#(
  parameter int MEM_AW = 16,
  parameter logic [MEM_AW-1:0] LOW_LAST  = 16'h0FFF,
  parameter logic [MEM_AW-1:0] TOP_FIRST = 16'hD000
) (
  input  logic                mem_req_n,
  input  logic [MEM_AW-1:0]   mem_addr,
  input  map_state_t          st,
  output logic [REGION_W-1:0] region_sel
);

  logic in_low, in_top;
  logic [REGION_W-1:0] low_code, top_code;

  assign in_low = (mem_addr <= LOW_LAST);
  assign in_top = (mem_addr >= TOP_FIRST);

  always_comb begin
    low_code = '0;
    top_code = '0;
    low_code[st.low_rom ? RGN_ROM : RGN_DRAM] = 1'b1;
    if (st.inhibit)       top_code[RGN_NONE] = 1'b1;
    else if (st.top_mmio) top_code[RGN_MMIO] = 1'b1;
    else                  top_code[RGN_DRAM] = 1'b1;
  end

  always_comb begin
    region_sel = '0;
    if (!mem_req_n) begin
      if (in_low)      region_sel = low_code;
      else if (in_top) region_sel = top_code;
      else             region_sel[RGN_DRAM] = 1'b1;
    end
  end

endmodule

// File: rtl/bank_mapper_top.sv
module bank_mapper_top
  import bank_map_pkg::*;
#(
  parameter int IO_AW  = 8,
  parameter int MEM_AW = 16,
  parameter logic [IO_AW-1:0]  PORT_BASE = 8'hE0,
  parameter logic [MEM_AW-1:0] LOW_LAST  = 16'h0FFF,
  parameter logic [MEM_AW-1:0] TOP_FIRST = 16'hD000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IO_AW-1:0]    io_addr,
  input  logic                iorq_n,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic                mem_req_n,
  input  logic [MEM_AW-1:0]   mem_addr,
  output logic [REGION_W-1:0] region_sel,
  output logic                irq_en
);

  map_cmd_t   cmd;
  map_state_t st;

  bmap_port_decode #(.IO_AW(IO_AW), .PORT_BASE(PORT_BASE)) u_dec (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .cmd(cmd)
  );

  bmap_state u_state (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .st(st)
  );

  bmap_region #(.MEM_AW(MEM_AW), .LOW_LAST(LOW_LAST), .TOP_FIRST(TOP_FIRST)) u_rgn (
    .mem_req_n(mem_req_n), .mem_addr(mem_addr), .st(st), .region_sel(region_sel)
  );

  assign irq_en = st.irq_en;

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int IO_AW  = 8,
  parameter int MEM_AW = 16,
  parameter logic [IO_AW-1:0]  PORT_BASE = 8'hE0,
  parameter logic [MEM_AW-1:0] LOW_LAST  = 16'h0FFF,
  parameter logic [MEM_AW-1:0] TOP_FIRST = 16'hD000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IO_AW-1:0]  io_addr,
  input logic              iorq_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              mem_req_n,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [3:0]        region_sel,
  input logic              irq_en
);

  localparam logic [IO_AW-1:0] IRQ_PORT = PORT_BASE + IO_AW'(7);

  logic wq, rq, c_wseen, c_rseen;
  assign wq = !iorq_n && !wr_n;
  assign rq = !iorq_n && !rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_wseen <= 1'b0;
      c_rseen <= 1'b0;
    end else begin
      c_wseen <= wq;
      c_rseen <= rq;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req_n |-> $countones(region_sel) == 1); // R11
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_n |-> region_sel == 4'b0000); // R11
  AST_MID_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && mem_addr > LOW_LAST && mem_addr < TOP_FIRST) |-> region_sel == 4'b0001); // R1
  AST_LOW_KINDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && mem_addr <= LOW_LAST) |-> region_sel[3:2] == 2'b00); // R2
  AST_TOP_NO_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_n && mem_addr >= TOP_FIRST) |-> !region_sel[1]); // R3
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wq && !c_wseen && io_addr == IRQ_PORT) |=> irq_en); // R7
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rq && !c_rseen && !wq && io_addr == IRQ_PORT) |=> !irq_en); // R7
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wq && c_wseen && !(rq && !c_rseen)) |=> $stable(irq_en)); // R10

endmodule

bind bank_mapper_top bank_mapper_chk #(
  .IO_AW(IO_AW), .MEM_AW(MEM_AW), .PORT_BASE(PORT_BASE),
  .LOW_LAST(LOW_LAST), .TOP_FIRST(TOP_FIRST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .iorq_n(iorq_n),
  .rd_n(rd_n), .wr_n(wr_n), .mem_req_n(mem_req_n), .mem_addr(mem_addr),
  .region_sel(region_sel), .irq_en(irq_en)
);

// File: tb/bank_mapper_top_test.sv
`timescale 1ns/1ps
module bank_mapper_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_addr = 8'h00;
  logic        iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic        mem_req_n = 1'b1;
  logic [15:0] mem_addr = 16'h0000;
  logic [3:0]  region_sel;
  logic        irq_en;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // Region codes (R11): bit0 DRAM, bit1 ROM, bit2 MMIO, bit3 none
  localparam logic [3:0] DRAM = 4'b0001, ROM = 4'b0010, MMIO = 4'b0100, NONE = 4'b1000;

  always #2.5 clk = ~clk;

  bank_mapper_top uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .mem_req_n(mem_req_n), .mem_addr(mem_addr),
    .region_sel(region_sel), .irq_en(irq_en)
  );

  // Behavioural reference model
  bit m_low_rom, m_top_mmio, m_inh, m_irq, m_wprev, m_rprev;

  function automatic logic [3:0] exp_region(input logic [15:0] a, input logic req_n);
    if (req_n) return 4'b0000;
    if (a < 16'h1000) return m_low_rom ? ROM : DRAM;
    if (a >= 16'hD000) return m_inh ? NONE : (m_top_mmio ? MMIO : DRAM);
    return DRAM;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_low_rom = 1; m_top_mmio = 1; m_inh = 0; m_irq = 0; m_wprev = 0; m_rprev = 0;
    end else begin
      bit w, r;
      w = !iorq_n && !wr_n;
      r = !iorq_n && !rd_n;
      if (w && !m_wprev) begin
        case (io_addr)
          8'hE0: m_low_rom = 0;
          8'hE1: m_top_mmio = 0;
          8'hE2: m_low_rom = 1;
          8'hE3: m_top_mmio = 1;
          8'hE4: begin m_low_rom = 1; m_top_mmio = 1; end
          8'hE5: m_inh = 1;
          8'hE6: m_inh = 0;
          8'hE7: m_irq = 1;
          default: ;
        endcase
      end else if (r && !m_rprev && io_addr == 8'hE7) begin
        m_irq = 0;
      end
      m_wprev = w;
      m_rprev = r;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    cycles++;
    #1;
    if (rst_n) begin
      check(region_sel == exp_region(mem_addr, mem_req_n), "R11 cycle region", region_sel, exp_region(mem_addr, mem_req_n));
      check(irq_en == m_irq, "R7 cycle irq_en", {3'b0, irq_en}, {3'b0, m_irq});
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  task automatic io_cycle(input logic [7:0] a, input bit is_wr, input int hold);
    @(negedge clk);
    io_addr = a; iorq_n = 0;
    if (is_wr) wr_n = 0; else rd_n = 0;
    repeat (hold) @(negedge clk);
    iorq_n = 1; wr_n = 1; rd_n = 1;
    @(negedge clk);
  endtask

  task automatic expect_region(input logic [15:0] a, input logic [3:0] exp, input string tag);
    @(negedge clk);
    mem_addr = a; mem_req_n = 0;
    #1;
    check(region_sel == exp, tag, region_sel, exp);
    @(negedge clk);
    mem_req_n = 1;
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    @(negedge clk);
    check(irq_en == exp, tag, {3'b0, irq_en}, {3'b0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(region_sel == 4'b0000, "R11 idle during reset", region_sel, 4'b0000);
    rst_n = 1;
    // R8 reset map
    expect_region(16'h0000, ROM,  "R8 low ROM after reset");
    expect_region(16'hE000, MMIO, "R8 top MMIO after reset");
    expect_region(16'h5000, DRAM, "R1 middle DRAM");
    expect_region(16'h0FFF, ROM,  "R1 low window edge");
    expect_region(16'hCFFF, DRAM, "R1 middle window edge");
    expect_region(16'hD000, MMIO, "R1 top window edge");
    expect_irq(1'b0, "R8 irq_en after reset");
    // R2
    io_cycle(8'hE0, 1, 1);
    expect_region(16'h0800, DRAM, "R2 E0 low DRAM");
    expect_region(16'hF000, MMIO, "R2 top unchanged");
    io_cycle(8'hE2, 1, 1);
    expect_region(16'h0800, ROM, "R2 E2 low ROM");
    // R3
    io_cycle(8'hE1, 1, 1);
    expect_region(16'hFFFF, DRAM, "R3 E1 top DRAM");
    expect_region(16'h0000, ROM,  "R3 low unchanged");
    io_cycle(8'hE3, 1, 1);
    expect_region(16'hFFFF, MMIO, "R3 E3 top MMIO");
    // R5 / R6
    io_cycle(8'hE1, 1, 1);
    io_cycle(8'hE5, 1, 1);
    expect_region(16'hD800, NONE, "R5 inhibit top none");
    expect_region(16'h0100, ROM,  "R5 low unaffected");
    io_cycle(8'hE6, 1, 1);
    expect_region(16'hD800, DRAM, "R6 restore DRAM");
    io_cycle(8'hE5, 1, 1);
    io_cycle(8'hE3, 1, 1);
    expect_region(16'hD800, NONE, "R6 still inhibited after E3");
    io_cycle(8'hE6, 1, 1);
    expect_region(16'hD800, MMIO, "R6 restore shows update");
    // R4
    io_cycle(8'hE0, 1, 1);
    io_cycle(8'hE1, 1, 1);
    io_cycle(8'hE4, 1, 1);
    expect_region(16'h0000, ROM,  "R4 default low");
    expect_region(16'hE000, MMIO, "R4 default top");
    // R7
    io_cycle(8'hE7, 1, 1);
    expect_irq(1'b1, "R7 write sets");
    io_cycle(8'hE7, 0, 1);
    expect_irq(1'b0, "R7 read clears");
    // R9 unqualified / partial address
    @(negedge clk); io_addr = 8'hE0; wr_n = 0; iorq_n = 1;
    repeat (2) @(negedge clk); wr_n = 1;
    expect_region(16'h0000, ROM, "R9 no iorq ignored");
    io_cycle(8'h60, 1, 1);
    expect_region(16'h0000, ROM, "R9 0x60 ignored");
    @(negedge clk); io_addr = 8'hE7; iorq_n = 0;
    repeat (2) @(negedge clk); iorq_n = 1;
    expect_irq(1'b0, "R9 iorq without strobe ignored");
    // R12
    io_cycle(8'hE0, 0, 1);
    expect_region(16'h0000, ROM, "R12 read of E0 ignored");
    io_cycle(8'hE5, 0, 1);
    expect_region(16'hE000, MMIO, "R12 read of E5 ignored");
    io_cycle(8'hE8, 1, 1);
    io_cycle(8'hD8, 1, 1);
    expect_region(16'h0000, ROM,  "R12 foreign ports low");
    expect_region(16'hE000, MMIO, "R12 foreign ports top");
    expect_irq(1'b0, "R12 foreign ports irq");
    // R10 first-edge timing and held strobe
    @(negedge clk); io_addr = 8'hE7; iorq_n = 0; wr_n = 0;
    #1; check(irq_en == 1'b0, "R10 before edge", {3'b0, irq_en}, 4'b0000);
    @(negedge clk);
    check(irq_en == 1'b1, "R10 after first edge", {3'b0, irq_en}, 4'b0001);
    iorq_n = 1; wr_n = 1;
    @(negedge clk); io_addr = 8'hE1; iorq_n = 0; wr_n = 0;
    @(negedge clk); io_addr = 8'hE3;
    repeat (3) @(negedge clk);
    iorq_n = 1; wr_n = 1;
    expect_region(16'hE000, DRAM, "R10 held strobe no second update");
    // R8 mid-run reset
    io_cycle(8'hE0, 1, 1);
    io_cycle(8'hE5, 1, 1);
    @(negedge clk); rst_n = 0;
    #1; check(irq_en == 1'b0, "R8 async irq clear", {3'b0, irq_en}, 4'b0000);
    @(negedge clk); rst_n = 1;
    expect_region(16'h0000, ROM,  "R8 mid-run low");
    expect_region(16'hE000, MMIO, "R8 mid-run top no inhibit");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule